// File: doc/BRIEF.md
# Interrupt Source Selector Mux

This block routes interrupt events to twelve maskable interrupt priority inputs of a processor core. It watches 128 event lines. Lines 0 to 3 carry the outputs of an event combiner, where each line stands for a group of events. Lines 4 to 127 are single events. Each of the twelve outputs has its own 8-bit routing field, which names the event line that the output copies. Output k drives core priority k+4, so the twelve outputs cover priorities 4 to 15.

The routing fields sit in 32-bit words, four fields to a word. Software changes them through a simple write port with byte enables, and reads them back through a combinational read port. Word address 0 is reserved and holds no fields. Field k lives in word address 1 + k/4, in bits (k%4)*8 to (k%4)*8+7. Each output is registered, so it follows its selected line one clock later.

Top module: `intsel_mux`

## Requirements
- R1: Each output prioIrq[k] is registered. On every clock it takes the value, sampled at that edge, of the event line named by field k. The change therefore appears one clock after the input changes.
- R2: Field k is held in word address 1 + k/4 at bits (k%4)*8 +: 8. For k = 0 to 3 that is address 1, for k = 4 to 7 address 2, and for k = 8 to 11 address 3.
- R3: After reset, field k holds k+4. Address 1 reads 0x07060504, address 2 reads 0x0B0A0908 and address 3 reads 0x0F0E0D0C. With this default routing, output k copies event line k+4.
- R4: A field value from 0 to 127 selects eventIn[value]. Values 0 to 3 select the combined-group lines.
- R5: A field value of 128 or more drives its output to 0, whatever the event lines do.
- R6: A write updates only the bytes whose wrBe bit is set (bit b covers bits 8b+7..8b). The other fields in the same word keep their values.
- R7: Reading an address from 1 to 3 returns the stored fields exactly as written, values of 128 and above included.
- R8: Address 0 is reserved. It reads as 0, and a write to it changes no field and no routing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe for one cycle |
| wrAddr | input | 2 | Word address of the write |
| wrData | input | 32 | Write data |
| wrBe | input | 4 | Byte enables of the write |
| rdAddr | input | 2 | Word address of the read |
| rdData | output | 32 | Read data, combinational from rdAddr |
| eventIn | input | 128 | Event lines; 0 to 3 are combined-group outputs |
| prioIrq | output | 12 | Routed outputs; bit k drives core priority k+4 |

## Verification
The assertions assume that the write inputs carry no X while wrEn is high, and that the event lines are stable around the sampling edge. The bench drives every input at the falling edge, so both assumptions hold. The checks on kept bytes and on ignored reserved writes assume that only the write port can change a field. The bench therefore issues at most one write per cycle, and it reads back every touched word before it moves to the next write pattern.

// File: rtl/intsel_pkg.sv
package intsel_pkg;
  localparam int NUM_OUT  = 12;
  localparam int SEL_W    = 8;
  localparam int NUM_EVT  = 128;
  localparam int PER_WORD = 4;
  localparam int WORD_W   = PER_WORD * SEL_W;
  localparam int ADDR_W   = 2;
  localparam int PRIO_BASE = 4;
  localparam int NUM_WORDS = NUM_OUT / PER_WORD;
  localparam int WIDX_W   = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;
  localparam int EVT_W    = $clog2(NUM_EVT);

  // strobes from control to datapath
  typedef struct packed {
    logic [NUM_WORDS-1:0] wordWr;
    logic [PER_WORD-1:0]  byteEn;
    logic                 rdHit;
    logic [WIDX_W-1:0]    rdWord;
  } strobe_t;
endpackage

// File: rtl/intsel_ctrl.sv
module intsel_ctrl
  import intsel_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [PER_WORD-1:0] wrBe,
  input  logic [ADDR_W-1:0] rdAddr,
  output strobe_t           strobe
);
  // word address 0 is reserved; fields start at address 1
  always_comb begin
    strobe = '0;
    strobe.byteEn = wrBe;
    for (int w = 0; w < NUM_WORDS; w++) begin
      if (wrEn && (wrAddr == ADDR_W'(w + 1))) strobe.wordWr[w] = 1'b1;
      if (rdAddr == ADDR_W'(w + 1)) begin
        strobe.rdHit  = 1'b1;
        strobe.rdWord = WIDX_W'(w);
      end
    end
  end

  // R2
  word_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobe.wordWr));

  // R8
  reserved_wr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == '0) |-> (strobe.wordWr == '0));
endmodule

// File: rtl/intsel_dp.sv
module intsel_dp
  import intsel_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            strobe,
  input  logic [WORD_W-1:0]  wrData,
  input  logic [NUM_EVT-1:0] eventIn,
  output logic [WORD_W-1:0]  rdData,
  output logic [NUM_OUT-1:0] prioIrq
);
  logic [SEL_W-1:0] selField [NUM_OUT];
  logic [NUM_OUT*SEL_W-1:0] flatSel;

  for (genvar k = 0; k < NUM_OUT; k++) begin : g_out
    localparam int WIDX = k / PER_WORD;
    localparam int BIDX = k % PER_WORD;

    always_ff @(posedge clk) begin
      if (!rstN)
        selField[k] <= SEL_W'(k + PRIO_BASE);
      else if (strobe.wordWr[WIDX] && strobe.byteEn[BIDX])
        selField[k] <= wrData[BIDX*SEL_W +: SEL_W];
    end

    always_ff @(posedge clk) begin
      if (!rstN)
        prioIrq[k] <= 1'b0;
      else if (selField[k] < SEL_W'(NUM_EVT))
        prioIrq[k] <= eventIn[selField[k][EVT_W-1:0]];
      else
        prioIrq[k] <= 1'b0;
    end

    assign flatSel[k*SEL_W +: SEL_W] = selField[k];

    // R6
    keep_byte_chk: assert property (@(posedge clk) disable iff (!rstN)
      (strobe.wordWr[WIDX] && !strobe.byteEn[BIDX]) |=> $stable(selField[k]));

    // R5
    high_sel_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
      (selField[k] >= SEL_W'(NUM_EVT)) |=> !prioIrq[k]);

    // R1
    follow_event_chk: assert property (@(posedge clk) disable iff (!rstN)
      ((selField[k] < SEL_W'(NUM_EVT)) && eventIn[selField[k][EVT_W-1:0]]) |=> prioIrq[k]);
  end

  always_comb begin
    if (strobe.rdHit)
      rdData = flatSel[int'(strobe.rdWord)*WORD_W +: WORD_W];
    else
      rdData = '0;
  end
endmodule

// File: rtl/intsel_mux.sv
module intsel_mux
  import intsel_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic [ADDR_W-1:0]   wrAddr,
  input  logic [WORD_W-1:0]   wrData,
  input  logic [PER_WORD-1:0] wrBe,
  input  logic [ADDR_W-1:0]   rdAddr,
  output logic [WORD_W-1:0]   rdData,
  input  logic [NUM_EVT-1:0]  eventIn,
  output logic [NUM_OUT-1:0]  prioIrq
);
  strobe_t strobe;

  intsel_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (wrEn),
    .wrAddr (wrAddr),
    .wrBe   (wrBe),
    .rdAddr (rdAddr),
    .strobe (strobe)
  );

  intsel_dp u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .wrData  (wrData),
    .eventIn (eventIn),
    .rdData  (rdData),
    .prioIrq (prioIrq)
  );
endmodule

// File: tb/intsel_mux_bench.sv
`timescale 1ns/1ps
module intsel_mux_bench;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         wrEn = 1'b0;
  logic [1:0]   wrAddr = '0;
  logic [31:0]  wrData = '0;
  logic [3:0]   wrBe = '0;
  logic [1:0]   rdAddr = '0;
  logic [31:0]  rdData;
  logic [127:0] eventIn = '0;
  logic [11:0]  prioIrq;

  int compared = 0;
  int mismatched = 0;
  logic [7:0] mSel [12];
  logic [11:0] expQ [$];
  string tagQ [$];

  always #5 clk = ~clk;

  intsel_mux u_intsel_mux (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .wrBe(wrBe), .rdAddr(rdAddr), .rdData(rdData), .eventIn(eventIn), .prioIrq(prioIrq)
  );

  function automatic logic [11:0] expOut(input logic [127:0] evt);
    logic [11:0] r;
    for (int k = 0; k < 12; k++)
      r[k] = (mSel[k] < 8'd128) ? evt[mSel[k][6:0]] : 1'b0;
    return r;
  endfunction

  function automatic logic [31:0] expWord(input int addr);
    if (addr == 0) return 32'h0;
    return {mSel[4*(addr-1)+3], mSel[4*(addr-1)+2], mSel[4*(addr-1)+1], mSel[4*(addr-1)]};
  endfunction

  function automatic logic [127:0] pattern(input int i);
    logic [31:0] a;
    a = 32'(i) * 32'h9E3779B9 + 32'h1234567;
    return {a ^ 32'hA5A5A5A5, ~a, {a[15:0], a[31:16]}, a * 32'h85EBCA6B};
  endfunction

  // driver: one cycle of stimulus, pushes the expected routed outputs
  task automatic step(input logic [127:0] evt, input logic we, input logic [1:0] addr,
                      input logic [31:0] data, input logic [3:0] be, input string tag);
    @(negedge clk);
    eventIn = evt;
    wrEn = we; wrAddr = addr; wrData = data; wrBe = be;
    expQ.push_back(expOut(evt));
    tagQ.push_back(tag);
    if (we && addr != 2'd0)
      for (int b = 0; b < 4; b++)
        if (be[b]) mSel[4*(int'(addr)-1)+b] = data[8*b +: 8];
  endtask

  task automatic readChk(input int addr, input string tag);
    @(negedge clk);
    wrEn = 1'b0;
    rdAddr = 2'(addr);
    #1;
    compared++;
    if (rdData !== expWord(addr)) begin
      mismatched++;
      $display("FAIL %s read addr %0d: actual %h expected %h", tag, addr, rdData, expWord(addr));
    end
  endtask

  // monitor: compare after each rising edge
  always @(posedge clk) begin
    #2;
    if (expQ.size() > 0) begin
      logic [11:0] e;
      string t;
      e = expQ.pop_front();
      t = tagQ.pop_front();
      compared++;
      if (prioIrq !== e) begin
        mismatched++;
        $display("FAIL %s prioIrq: actual %h expected %h", t, prioIrq, e);
      end
    end
  end

  initial begin
    #2000000;
    mismatched++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    for (int k = 0; k < 12; k++) mSel[k] = 8'(k + 4);
    repeat (3) @(negedge clk);
    #2;
    compared++;
    if (prioIrq !== 12'h0) begin
      mismatched++;
      $display("FAIL R1 reset output: actual %h expected 000", prioIrq);
    end
    rstN = 1'b1;

    // R3 reset routing values, R2 field placement
    for (int a = 0; a < 4; a++) readChk(a, "R3");

    // R1 default routing follows lines 4..15 one clock later
    step(128'h0, 0, 0, 0, 0, "R1");
    step({8{16'hFFF0}}, 0, 0, 0, 0, "R1");
    for (int i = 0; i < 16; i++) step(128'h1 << (i + 4), 0, 0, 0, 0, "R1");
    for (int i = 0; i < 20; i++) step(pattern(i), 0, 0, 0, 0, "R1");

    // R4 combined-group lines 0..3 on outputs 0..3
    step(pattern(40), 1, 2'd1, 32'h03020100, 4'hF, "R4");
    for (int i = 0; i < 8; i++) step(128'h1 << (i % 4), 0, 0, 0, 0, "R4");
    readChk(1, "R2");

    // R6 single byte write, R5 value above 127
    step(pattern(50), 1, 2'd2, 32'hDEAD85BE, 4'b0010, "R6");
    readChk(2, "R6");
    for (int i = 0; i < 8; i++) step(~128'h0 ^ pattern(60 + i), 0, 0, 0, 0, "R5");
    step(~128'h0, 1, 2'd3, 32'h7FFF807F, 4'b1101, "R5");
    for (int i = 0; i < 4; i++) step(~128'h0, 0, 0, 0, 0, "R5");
    // R7 readback unchanged, including values above 127
    readChk(3, "R7");
    readChk(2, "R7");

    // R2 high bytes of each word, spread sources
    step(pattern(70), 1, 2'd2, 32'h7B2A5010, 4'b1001, "R2");
    step(pattern(71), 1, 2'd3, 32'h64FF3C11, 4'b0110, "R2");
    for (int i = 0; i < 12; i++) step(pattern(80 + i), 0, 0, 0, 0, "R2");
    for (int a = 1; a < 4; a++) readChk(a, "R7");

    // R8 reserved address: writes ignored, reads zero
    step(pattern(90), 1, 2'd0, 32'h00000000, 4'hF, "R8");
    step(pattern(91), 1, 2'd0, 32'hFFFFFFFF, 4'hF, "R8");
    for (int i = 0; i < 10; i++) step(pattern(92 + i), 0, 0, 0, 0, "R8");
    for (int a = 0; a < 4; a++) readChk(a, "R8");

    repeat (3) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule